// File: doc/BRIEF.md
# Six-Mode Programmable Counter Channel

One down-counter channel of an interval timer. The channel advances only on cycles where the count-enable `tick` is high. Every other input acts on the next rising edge of `clk`. Software, or a host sequencer, first writes an operating mode and a binary or BCD selection. It then supplies an initial count N through a small load port. The channel drives a waveform on `out_o` and exposes its live count on `count_o`.

Six modes are available:

| Code | Mode | Behaviour |
|------|------|-----------|
| 0 | Terminal flag | One-shot; started by a count write; gated by the `gate` level |
| 1 | Gate-triggered one-shot | One-shot; started by a `gate` rising edge |
| 2 | Rate generator | Periodic; narrow low pulse once per period; self-reloading |
| 3 | Square wave | Periodic; count steps by two; self-reloading |
| 4 | Strobe | Single strobe; started by a count write |
| 5 | Gate-triggered strobe | Single strobe; started by a `gate` rising edge |

Codes 6 and 7 select modes 2 and 3. The one-shot and strobe modes do not stop at zero. They wrap to the largest count and keep counting. The periodic modes reload N themselves.

The load port is a valid/ready stream. `load_ready` is held high at all times, so the port never applies back-pressure. A word is consumed on every clock where `load_valid` is high. When `mode_wr` and `load_valid` are high on the same clock, the mode write wins and the word is dropped. A load wins over a `gate` edge and over a tick on the same clock.

Top module: `interval_counter_channel`

## Requirements
- R1: Reset state:
  - After reset, `count_o` is 0, `out_o` is low and the channel is in mode 0 without counting.
  - Ticks have no effect until a count is loaded.
- R2: Mode 0 (terminal flag):
  - A count write loads N into the count and drives `out_o` low.
  - `out_o` rises on the tick that brings the count to zero, after N ticks, and then stays high.
  - The count continues past zero by wrapping.
- R3: In modes 0 and 4, ticks count only while `gate` is high. While `gate` is low, the count holds.
- R4: An initial count of 0 behaves as 65536 in binary and as 10000 in BCD.
- R5: BCD counting (`bcd_sel`=1):
  - Each 4-bit field of `count_o` holds one decimal digit, with the least significant digit in bits 3:0.
  - Decrementing borrows decimally, and 0000 wraps to 9999.
  - In binary, 0000 wraps to FFFF.
- R6: Mode 1 (gate-triggered one-shot):
  - A count write only stores N; it does not start counting.
  - A `gate` rising edge loads N and drives `out_o` low. `out_o` goes high after N ticks.
  - The `gate` level does not stop counting. A further rising edge restarts from N.
- R7: Mode 2 (rate generator):
  - The count runs N down to 1.
  - The tick at count 1 reloads N and drives `out_o` low for one tick interval, giving a period of N ticks.
  - `out_o` is high when counting starts. A `gate` rising edge restarts from N.
- R8: Mode 3 (square wave), for N of at least 2:
  - `out_o` is high for (N+1)/2 ticks and low for N/2 ticks of each N-tick period.
  - The count starts at N rounded down to even and drops by two per tick.
- R9: Modes 4 and 5 (strobes):
  - `out_o` drops for exactly one tick interval when the count first reaches zero after a start.
  - It is not driven low again when the count wraps round to zero.
  - Mode 4 starts on a count write; mode 5 starts on a `gate` rising edge.
- R10: A mode write has these effects:
  - It stops counting and clears `count_o` to 0.
  - It sets `out_o` low for mode 0 and high for every other mode.
  - Codes 6 and 7 select modes 2 and 3.
- R11: Load port:
  - `load_ready` is always high.
  - In modes 0, 2, 3 and 4 a load starts counting from N with the next tick.
  - Every result appears one clock after the edge that samples its cause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable, one clock per count step |
| mode_wr | input | 1 | Mode write strobe |
| mode_sel | input | 3 | Mode code 0..7 |
| bcd_sel | input | 1 | 1 selects BCD counting |
| load_valid | input | 1 | Initial count word valid |
| load_ready | output | 1 | Always high; no back-pressure |
| load_data | input | 4*DIGITS | Initial count (0 means maximum) |
| gate | input | 1 | Gate level, sampled every clock |
| out_o | output | 1 | Channel waveform |
| count_o | output | 4*DIGITS | Live count |

## Verification
Every effect is registered once. A mode write, a load, a `gate` edge or a tick sampled at one rising edge therefore shows on `count_o` and `out_o` straight after that edge, and no later. The bench changes inputs only on falling edges and reads the outputs at the following falling edge, half a period after the edge that updated them. For each started run, a function of the mode, N and the number of elapsed ticks gives the expected count and level. That function is compared after every clock of random tick patterns. Long directed runs cover the full-range count and the single strobe across a wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    MD_TERM     = 3'd0,
    MD_ONESHOT  = 3'd1,
    MD_RATE     = 3'd2,
    MD_SQUARE   = 3'd3,
    MD_SWSTROBE = 3'd4,
    MD_HWSTROBE = 3'd5
  } tmr_mode_e;

  // Per-mode start and gating properties
  typedef struct packed {
    logic load_start;   // a count write starts counting
    logic edge_start;   // a gate rising edge (re)starts counting
    logic level_gated;  // gate low holds the count
  } tmr_attr_t;

  // Codes 6 and 7 alias the periodic modes 2 and 3
  function automatic tmr_mode_e fold_mode(input logic [2:0] code);
    return tmr_mode_e'((code > 3'd5) ? (code - 3'd4) : code);
  endfunction

endpackage

// File: rtl/tmr_count_dec.sv
module tmr_count_dec #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] val,
  input  logic                bcd,
  output logic [4*DIGITS-1:0] nxt
);
  localparam int CW = 4 * DIGITS;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [DIGITS:0]   borrow;
  logic [CW-1:0]     dec_bcd;
  logic [CW-1:0]     dec_bin;

  assign borrow[0] = 1'b1;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    logic [3:0] dig;
    assign dig = val[4*i +: 4];
    assign dec_bcd[4*i +: 4] = !borrow[i]     ? dig  :
                               (dig == 4'd0)  ? 4'd9 : 4'(dig - 4'd1);
    assign borrow[i+1] = borrow[i] & (dig == 4'd0);
  end

  assign dec_bin = val - ONE;
  assign nxt     = bcd ? dec_bcd : dec_bin;

endmodule

// File: rtl/tmr_gate_edge.sv
module tmr_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic rise
);
  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign rise = gate & ~gate_q;

endmodule

// File: rtl/tmr_mode_attr.sv
module tmr_mode_attr
  import tmr_pkg::*;
(
  input  tmr_mode_e mode,
  output tmr_attr_t attr
);
  always_comb begin
    unique case (mode)
      MD_TERM, MD_SWSTROBE: attr = '{load_start: 1'b1, edge_start: 1'b0, level_gated: 1'b1};
      MD_ONESHOT, MD_HWSTROBE: attr = '{load_start: 1'b0, edge_start: 1'b1, level_gated: 1'b0};
      MD_RATE, MD_SQUARE:   attr = '{load_start: 1'b1, edge_start: 1'b1, level_gated: 1'b0};
      default:              attr = '{load_start: 1'b0, edge_start: 1'b0, level_gated: 1'b0};
    endcase
  end

endmodule

// File: rtl/interval_counter_channel.sv
module interval_counter_channel
  import tmr_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                mode_wr,
  input  logic [2:0]          mode_sel,
  input  logic                bcd_sel,
  input  logic                load_valid,
  output logic                load_ready,
  input  logic [4*DIGITS-1:0] load_data,
  input  logic                gate,
  output logic                out_o,
  output logic [4*DIGITS-1:0] count_o
);
  localparam int CW = 4 * DIGITS;
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  tmr_mode_e     mode_q;
  tmr_attr_t     attr;
  logic          bcd_q;
  logic [CW-1:0] init_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          out_q;
  logic          fired_q;   // strobe already issued since the last start
  logic          hold_q;    // extra high tick of an odd square-wave period
  logic [CW-1:0] dec1;
  logic [CW-1:0] dec2;
  logic [CW-1:0] load_even;
  logic [CW-1:0] init_even;
  logic          gate_rise;
  logic          step;

  tmr_count_dec #(.DIGITS(DIGITS)) u_dec1 (.val(cnt_q), .bcd(bcd_q), .nxt(dec1));
  tmr_count_dec #(.DIGITS(DIGITS)) u_dec2 (.val(dec1),  .bcd(bcd_q), .nxt(dec2));

  tmr_gate_edge u_gate (.clk(clk), .rst_n(rst_n), .gate(gate), .rise(gate_rise));

  tmr_mode_attr u_attr (.mode(mode_q), .attr(attr));

  assign load_even = {load_data[CW-1:1], 1'b0};
  assign init_even = {init_q[CW-1:1], 1'b0};
  assign step      = run_q & tick & (~attr.level_gated | gate);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_TERM;
      bcd_q   <= 1'b0;
      init_q  <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      out_q   <= 1'b0;
      fired_q <= 1'b0;
      hold_q  <= 1'b0;
    end else if (mode_wr) begin
      mode_q  <= fold_mode(mode_sel);
      bcd_q   <= bcd_sel;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      out_q   <= (fold_mode(mode_sel) != MD_TERM);
      fired_q <= 1'b0;
      hold_q  <= 1'b0;
    end else if (load_valid) begin
      init_q <= load_data;
      if (attr.load_start) begin
        cnt_q   <= (mode_q == MD_SQUARE) ? load_even : load_data;
        run_q   <= 1'b1;
        out_q   <= (mode_q != MD_TERM);
        fired_q <= 1'b0;
        hold_q  <= 1'b0;
      end
    end else if (gate_rise && attr.edge_start) begin
      cnt_q   <= (mode_q == MD_SQUARE) ? init_even : init_q;
      run_q   <= 1'b1;
      out_q   <= (mode_q != MD_ONESHOT);
      fired_q <= 1'b0;
      hold_q  <= 1'b0;
    end else if (step) begin
      unique case (mode_q)
        MD_RATE: begin
          if (cnt_q == ONE) begin
            cnt_q <= init_q;
            out_q <= 1'b0;
          end else begin
            cnt_q <= dec1;
            out_q <= 1'b1;
          end
        end
        MD_SQUARE: begin
          if (hold_q) begin
            hold_q <= 1'b0;
            out_q  <= 1'b0;
            cnt_q  <= init_even;
          end else if (cnt_q == TWO) begin
            if (out_q && init_q[0]) begin
              hold_q <= 1'b1;
              cnt_q  <= dec2;
            end else begin
              out_q <= ~out_q;
              cnt_q <= init_even;
            end
          end else begin
            cnt_q <= dec2;
          end
        end
        MD_SWSTROBE, MD_HWSTROBE: begin
          cnt_q <= dec1;
          if (cnt_q == ONE && !fired_q) begin
            out_q   <= 1'b0;
            fired_q <= 1'b1;
          end else begin
            out_q <= 1'b1;
          end
        end
        default: begin  // terminal flag and gate-triggered one-shot
          cnt_q <= dec1;
          if (cnt_q == ONE) out_q <= 1'b1;
        end
      endcase
    end
  end

  assign load_ready = 1'b1;
  assign out_o      = out_q;
  assign count_o    = cnt_q;

endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
  import tmr_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic                mode_wr,
  input logic [2:0]          mode_sel,
  input logic                load_valid,
  input logic                gate,
  input logic                out_o,
  input logic [4*DIGITS-1:0] count_o,
  input tmr_mode_e           mode_q,
  input logic                fired_q,
  input logic                gate_rise
);
  localparam logic [4*DIGITS-1:0] ONE = (4*DIGITS)'(1);

  // R1: reset leaves the count at zero and the output low
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (count_o == '0 && !out_o));

  // R3: gate low holds the count in the level-gated modes
  a_r3_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_TERM || mode_q == MD_SWSTROBE) && !gate && !mode_wr && !load_valid)
    |=> $stable(count_o));

  // R2: once raised in mode 0 the flag stays until reprogrammed
  a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_TERM && out_o && !mode_wr && !load_valid) |=> out_o);

  // R6: a finished one-shot stays high until a new trigger
  a_r6_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_ONESHOT && out_o && !mode_wr && !load_valid && !gate_rise) |=> out_o);

  // R7: the rate pulse lasts one tick interval
  a_r7_rate_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_RATE && !out_o && tick && count_o != ONE && !mode_wr && !load_valid)
    |=> out_o);

  // R9: a strobe falls only when it is first issued after a start
  a_r9_strobe_once: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(out_o) && (mode_q == MD_SWSTROBE || mode_q == MD_HWSTROBE)) |-> $rose(fired_q));

  // R10: mode write sets the idle level of the output and clears the count
  a_r10_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (out_o == ($past(mode_sel) != 3'd0) && count_o == '0));

endmodule

bind interval_counter_channel tmr_chan_chk #(.DIGITS(DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mode_wr(mode_wr), .mode_sel(mode_sel),
  .load_valid(load_valid), .gate(gate), .out_o(out_o), .count_o(count_o),
  .mode_q(mode_q), .fired_q(fired_q), .gate_rise(gate_rise)
);

// File: tb/test_interval_counter_channel.sv
module test_interval_counter_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        mode_wr = 1'b0;
  logic [2:0]  mode_sel = 3'd0;
  logic        bcd_sel = 1'b0;
  logic        load_valid = 1'b0;
  logic        load_ready;
  logic [15:0] load_data = 16'd0;
  logic        gate = 1'b1;
  logic        out_o;
  logic [15:0] count_o;

  int nerr = 0;
  int nchk = 0;
  bit done = 1'b0;

  interval_counter_channel #(.DIGITS(4)) i_interval_counter_channel (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_wr(mode_wr), .mode_sel(mode_sel),
    .bcd_sel(bcd_sel), .load_valid(load_valid), .load_ready(load_ready),
    .load_data(load_data), .gate(gate), .out_o(out_o), .count_o(count_o)
  );

  always #10ns clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one rising edge, then back to the falling edge for sampling
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] enc(input int v, input bit bcd);
    if (!bcd) return v[15:0];
    return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
  endfunction

  function automatic int full(input bit bcd);
    return bcd ? 10000 : 65536;
  endfunction

  function automatic logic [15:0] exp_count(input int fm, input bit bcd, input int n, input int d);
    int m = full(bcd);
    int nn = (n == 0) ? m : n;
    int v;
    int p;
    int hi;
    case (fm)
      2: v = nn - (d % nn);
      3: begin
        p  = d % nn;
        hi = (nn + 1) / 2;
        v  = (p < hi) ? ((nn & ~1) - 2 * p) : ((nn & ~1) - 2 * (p - hi));
      end
      default: v = nn - (d % m) + m;
    endcase
    return enc(v % m, bcd);
  endfunction

  function automatic logic exp_out(input int fm, input bit bcd, input int n, input int d);
    int nn = (n == 0) ? full(bcd) : n;
    case (fm)
      0, 1: return d >= nn;
      2: return !(d > 0 && d % nn == 0);
      3: return (d % nn) < (nn + 1) / 2;
      default: return d != nn;
    endcase
  endfunction

  function automatic string req_of(input int fm);
    case (fm)
      0: return "R2";
      1: return "R6";
      2: return "R7";
      3: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic prog(input int code, input bit bcd);
    mode_wr = 1'b1; mode_sel = code[2:0]; bcd_sel = bcd;
    cyc();
    mode_wr = 1'b0;
  endtask

  task automatic load(input int n, input bit bcd);
    load_valid = 1'b1; load_data = enc(n, bcd);
    cyc();
    load_valid = 1'b0;
  endtask

  task automatic ticks(input int k);
    tick = 1'b1;
    repeat (k) cyc();
    tick = 1'b0;
  endtask

  task automatic run_model(input int code, input bit bcd, input int n, input int nt);
    int fm = (code > 5) ? code - 4 : code;
    string rq = req_of(fm);
    int d = 0;
    bit edge_mode = (fm == 1 || fm == 5);
    gate = edge_mode ? 1'b0 : 1'b1;
    prog(code, bcd);
    chk("R10", {31'd0, out_o}, {31'd0, fm != 0});
    chk("R10", {16'd0, count_o}, 32'd0);
    load(n, bcd);
    chk("R11", {31'd0, load_ready}, 32'd1);
    if (edge_mode) begin
      gate = 1'b1;
      cyc();
    end
    chk(rq, {16'd0, count_o}, {16'd0, exp_count(fm, bcd, n, 0)});
    chk(rq, {31'd0, out_o}, {31'd0, exp_out(fm, bcd, n, 0)});
    for (int i = 0; i < nt; i++) begin
      bit t = 1'($urandom % 2);
      tick = t;
      cyc();
      tick = 1'b0;
      if (t) d++;
      chk(rq, {16'd0, count_o}, {16'd0, exp_count(fm, bcd, n, d)});
      chk(rq, {31'd0, out_o}, {31'd0, exp_out(fm, bcd, n, d)});
    end
    gate = 1'b1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    int unsigned seed = $urandom(32'h5eed);
    int lows;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, ticks ignored before any load
    chk("R1", {16'd0, count_o}, 32'd0);
    chk("R1", {31'd0, out_o}, 32'd0);
    chk("R11", {31'd0, load_ready}, 32'd1);
    ticks(4);
    chk("R1", {16'd0, count_o}, 32'd0);
    chk("R1", {31'd0, out_o}, 32'd0);

    // R3 with R2: gate low pauses mode 0
    gate = 1'b1;
    prog(0, 1'b0);
    load(5, 1'b0);
    chk("R2", {16'd0, count_o}, 32'd5);
    ticks(2);
    chk("R2", {16'd0, count_o}, 32'd3);
    gate = 1'b0;
    ticks(3);
    chk("R3", {16'd0, count_o}, 32'd3);
    chk("R3", {31'd0, out_o}, 32'd0);
    gate = 1'b1;
    ticks(3);
    chk("R2", {16'd0, count_o}, 32'd0);
    chk("R2", {31'd0, out_o}, 32'd1);
    ticks(1);
    chk("R5", {16'd0, count_o}, 32'hffff);
    chk("R2", {31'd0, out_o}, 32'd1);

    // R4: zero as full range, BCD mode 0
    prog(0, 1'b1);
    load(0, 1'b1);
    ticks(9999);
    chk("R4", {16'd0, count_o}, 32'h0001);
    chk("R4", {31'd0, out_o}, 32'd0);
    ticks(1);
    chk("R4", {16'd0, count_o}, 32'h0000);
    chk("R4", {31'd0, out_o}, 32'd1);
    ticks(1);
    chk("R5", {16'd0, count_o}, 32'h9999);

    // R4: zero as full range, binary mode 4
    prog(4, 1'b0);
    load(0, 1'b0);
    ticks(65535);
    chk("R4", {16'd0, count_o}, 32'd1);
    chk("R9", {31'd0, out_o}, 32'd1);
    ticks(1);
    chk("R9", {31'd0, out_o}, 32'd0);
    ticks(1);
    chk("R9", {31'd0, out_o}, 32'd1);
    chk("R4", {16'd0, count_o}, 32'hffff);

    // R5: decimal borrow in mode 2
    prog(2, 1'b1);
    load(12, 1'b1);
    ticks(2);
    chk("R5", {16'd0, count_o}, 32'h0010);
    ticks(1);
    chk("R5", {16'd0, count_o}, 32'h0009);

    // R10: mode write mid-count stops and clears
    prog(2, 1'b1);
    chk("R10", {16'd0, count_o}, 32'd0);
    ticks(5);
    chk("R10", {16'd0, count_o}, 32'd0);
    chk("R10", {31'd0, out_o}, 32'd1);

    // R6: load alone does not start; gate level ignored; retrigger
    gate = 1'b0;
    prog(1, 1'b0);
    load(10, 1'b0);
    ticks(3);
    chk("R6", {16'd0, count_o}, 32'd0);
    chk("R6", {31'd0, out_o}, 32'd1);
    gate = 1'b1;
    cyc();
    chk("R6", {16'd0, count_o}, 32'd10);
    chk("R6", {31'd0, out_o}, 32'd0);
    ticks(4);
    gate = 1'b0;
    ticks(2);
    chk("R6", {16'd0, count_o}, 32'd4);
    gate = 1'b1;
    cyc();
    chk("R6", {16'd0, count_o}, 32'd10);
    ticks(9);
    chk("R6", {31'd0, out_o}, 32'd0);
    ticks(1);
    chk("R6", {31'd0, out_o}, 32'd1);

    // R9: mode 5 strobe issued once, not repeated after a full wrap
    gate = 1'b0;
    prog(5, 1'b1);
    load(3, 1'b1);
    gate = 1'b1;
    cyc();
    ticks(3);
    chk("R9", {31'd0, out_o}, 32'd0);
    lows = 0;
    tick = 1'b1;
    for (int i = 0; i < 10000; i++) begin
      cyc();
      if (!out_o) lows++;
    end
    tick = 1'b0;
    chk("R9", lows, 32'd0);
    chk("R9", {16'd0, count_o}, 32'h0000);

    // R10 alias plus R8: code 7 as square wave, odd and even counts
    run_model(7, 1'b0, 5, 40);
    run_model(3, 1'b1, 8, 40);
    run_model(6, 1'b0, 1, 10);

    // random runs across all codes
    for (int r = 0; r < 40; r++) begin
      int code = int'($urandom % 8);
      int fm = (code > 5) ? code - 4 : code;
      bit bcd = 1'($urandom % 2);
      int n = int'($urandom % 39) + 2;
      if ($urandom % 10 == 0 && fm != 3) n = 0;
      run_model(code, bcd, n, 40 + int'($urandom % 40));
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule